// File: doc/BRIEF.md
# Down-Counting Event Timer

This block is a register-programmed event timer. Software places a start value in a load register pair and sets the run bit. On the next cycle the counter takes that value, and from then on it steps down by one on every cycle where `tick_en` is high. When the count runs out, the block either stops at zero (one-shot) or takes the load value again and keeps going (periodic). The counter can be 32 or 64 bits wide, chosen at run time. Each expiry sets a raw pending flag. That flag is masked by an enable to drive a level interrupt, and software clears it by writing a one.

Control is a three-state machine. `ST_IDLE` is stopped, with the counter holding its value. `ST_RUN` is counting. `ST_DONE` is a finished one-shot, with the counter held at zero. The transitions are:
- start: `ST_IDLE` to `ST_RUN` when the run bit is 1. This loads the counter.
- finish: `ST_RUN` to `ST_DONE` on expiry in one-shot mode.
- stop: `ST_RUN` or `ST_DONE` to `ST_IDLE` when the run bit is 0.

Periodic expiry stays in `ST_RUN`.

A separate shadow pair follows the live count one cycle behind. Reading its low word freezes it for one further bus access. A low-then-high read pair therefore returns a consistent 64-bit value. Because the count runs downward, the bitwise inverse of the low shadow word gives a rising timestamp.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The byte offsets are:

  | Offset | Register |
  |---|---|
  | 0x00 | load low |
  | 0x04 | load high |
  | 0x08 | live count low |
  | 0x0C | live count high |
  | 0x10 | control |
  | 0x14 | interrupt |
  | 0x18 | shadow low |
  | 0x1C | shadow high |

- R2: The start transition copies the load value into the counter in the cycle after the run bit is written. In 64-bit mode both halves are copied. In 32-bit mode only the low half is copied, and the counter high word reads 0.
- R3: In `ST_RUN` the count drops by exactly one per cycle with `tick_en` high, and it does not change on other cycles.
- R4: In one-shot mode (control bit 0 = 0), a tick when the count is 1 or less expires the timer. The counter then reads 0 and stays at 0 whatever the ticks, until the run bit is cleared and set again.
- R5: In periodic mode (control bit 0 = 1), a tick when the count is 1 or less expires the timer and reloads the load value. Counting continues without any bus write.
- R6: With control bit 16 = 1 the counter is 64 bits wide, so a borrow passes from the low word into the high word.
- R7: Control bits 0, 1 and 16 read back as written, and all other bits read 0. Writing the control word with bit 1 = 0 stops counting and holds the count.
- R8: Interrupt register bit 1 (raw) sets on every expiry, whatever the value of the enable bit (bit 0).
- R9: Interrupt bit 2 reads raw AND enable, and `irq` equals that masked value.
- R10: Writing interrupt bit 3 as 1 clears raw. Bit 3 always reads 0. Writes to bits 1 and 2 have no effect.
- R11: If a clear write and an expiry fall in the same cycle, raw stays 1.
- R12: The shadow words copy the live count every cycle. A read of shadow low freezes them until the next bus access, so a later shadow-high read matches the low read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one step per high cycle |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used for the shadow freeze) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt, the masked pending flag |

## Verification
If the run state is wrong, the live count shows it within one tick. The count either fails to load the cycle after start, keeps moving after a one-shot has finished, or fails to reload in periodic mode. A wrong pending flag or priority shows on the interrupt register and on `irq` one cycle after the expiry or clear write that exposed it. A freeze that is missing or released too early shows as a shadow-high word that disagrees with the low word read just before it. This is visible across a borrow from the low word into the high word.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned ADDR_W = 5;

    typedef logic [ADDR_W-1:0] reg_off_t;

    localparam reg_off_t OFF_LOAD_LO = 5'h00;
    localparam reg_off_t OFF_LOAD_HI = 5'h04;
    localparam reg_off_t OFF_CNT_LO  = 5'h08;
    localparam reg_off_t OFF_CNT_HI  = 5'h0C;
    localparam reg_off_t OFF_CTL     = 5'h10;
    localparam reg_off_t OFF_INT     = 5'h14;
    localparam reg_off_t OFF_SHD_LO  = 5'h18;
    localparam reg_off_t OFF_SHD_HI  = 5'h1C;

    localparam int unsigned CTL_PER_BIT  = 0;
    localparam int unsigned CTL_RUN_BIT  = 1;
    localparam int unsigned CTL_WIDE_BIT = 16;

    localparam int unsigned INT_IE_BIT  = 0;
    localparam int unsigned INT_RAW_BIT = 1;
    localparam int unsigned INT_MSK_BIT = 2;
    localparam int unsigned INT_CLR_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;
endpackage

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [2*DW-1:0] load,
    input  logic            run,
    input  logic            periodic,
    input  logic            wide,
    output logic [2*DW-1:0] count,
    output logic            expire
);
    localparam int unsigned CW = 2 * DW;

    run_state_t      state, state_nx;
    logic [CW-1:0]   load_eff;
    logic [CW-1:0]   cnt_view;

    assign load_eff = wide ? load : {{DW{1'b0}}, load[DW-1:0]};
    assign cnt_view = wide ? count : {{DW{1'b0}}, count[DW-1:0]};
    assign expire   = (state == ST_RUN) && run && tick_en
                      && (cnt_view <= CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, finish, stop
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run) state_nx = ST_RUN;
            ST_RUN: begin
                if (!run)                     state_nx = ST_IDLE;
                else if (expire && !periodic) state_nx = ST_DONE;
            end
            ST_DONE: if (!run) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // counter (output process)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (run) count <= load_eff;
                ST_RUN: begin
                    if (run && tick_en) begin
                        if (expire) count <= periodic ? load_eff : '0;
                        else        count <= cnt_view - CW'(1);
                    end
                end
                default: count <= count;
            endcase
        end
    end

    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run) |=> count[DW-1:0] == $past(load[DW-1:0]));
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick_en) |=> $stable(count));
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> $stable(count));
endmodule

// File: rtl/cdt_shadow.sv
module cdt_shadow #(
    parameter int unsigned CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] live,
    input  logic          freeze_set,
    input  logic          access,
    output logic [CW-1:0] shadow
);
    logic frozen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen <= 1'b0;
            shadow <= '0;
        end else begin
            if (freeze_set)  frozen <= 1'b1;
            else if (access) frozen <= 1'b0;
            if (!frozen && !freeze_set) shadow <= live;
        end
    end

    a_r12_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !access) |=> $stable(shadow));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  reg_off_t        addr,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic [2*DW-1:0] count,
    input  logic [2*DW-1:0] shadow,
    input  logic            expire,
    output logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] load,
    output logic            run,
    output logic            periodic,
    output logic            wide,
    output logic            irq
);
    logic ie, raw;
    logic clr_wr;

    assign clr_wr = we && (addr == OFF_INT) && wdata[INT_CLR_BIT];
    assign irq    = raw & ie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load     <= '0;
            run      <= 1'b0;
            periodic <= 1'b0;
            wide     <= 1'b0;
            ie       <= 1'b0;
            raw      <= 1'b0;
        end else begin
            if (we) begin
                unique case (addr)
                    OFF_LOAD_LO: load[DW-1:0]    <= wdata;
                    OFF_LOAD_HI: load[2*DW-1:DW] <= wdata;
                    OFF_CTL: begin
                        periodic <= wdata[CTL_PER_BIT];
                        run      <= wdata[CTL_RUN_BIT];
                        wide     <= wdata[CTL_WIDE_BIT];
                    end
                    OFF_INT: ie <= wdata[INT_IE_BIT];
                    default: ;
                endcase
            end
            if (expire)      raw <= 1'b1;
            else if (clr_wr) raw <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_LOAD_LO: rdata = load[DW-1:0];
            OFF_LOAD_HI: rdata = load[2*DW-1:DW];
            OFF_CNT_LO:  rdata = count[DW-1:0];
            OFF_CNT_HI:  rdata = count[2*DW-1:DW];
            OFF_CTL: begin
                rdata[CTL_PER_BIT]  = periodic;
                rdata[CTL_RUN_BIT]  = run;
                rdata[CTL_WIDE_BIT] = wide;
            end
            OFF_INT: begin
                rdata[INT_IE_BIT]  = ie;
                rdata[INT_RAW_BIT] = raw;
                rdata[INT_MSK_BIT] = raw & ie;
            end
            OFF_SHD_LO: rdata = shadow[DW-1:0];
            OFF_SHD_HI: rdata = shadow[2*DW-1:DW];
            default:    rdata = '0;
        endcase
    end

    a_r8_raw_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);
    a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_INT && !wdata[INT_CLR_BIT] && !expire) |=> raw == $past(raw));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int unsigned CW = 2 * DW;

    logic [CW-1:0] load, count, shadow;
    logic          run, periodic, wide, expire;
    logic          low_shadow_rd;

    assign low_shadow_rd = bus_re && (bus_addr == OFF_SHD_LO);

    cdt_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .count(count), .shadow(shadow), .expire(expire),
        .rdata(bus_rdata), .load(load), .run(run), .periodic(periodic),
        .wide(wide), .irq(irq)
    );

    cdt_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load), .run(run),
        .periodic(periodic), .wide(wide), .count(count), .expire(expire)
    );

    cdt_shadow #(.CW(CW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .live(count), .freeze_set(low_shadow_rd),
        .access(bus_re || bus_we), .shadow(shadow)
    );
endmodule

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cdt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] load;
        logic        per;
        logic [7:0]  ticks;
        logic [31:0] exp_cnt;
        logic [31:0] exp_int;
    } vec_t;

    // one-shot/periodic table, 32-bit width, interrupt enabled
    localparam vec_t VECS [8] = '{
        '{32'd5, 1'b0, 8'd2, 32'd3, 32'h1},  // R3 steps down
        '{32'd5, 1'b0, 8'd5, 32'd0, 32'h7},  // R4 expiry
        '{32'd5, 1'b0, 8'd8, 32'd0, 32'h7},  // R4 holds at zero
        '{32'd4, 1'b1, 8'd4, 32'd4, 32'h7},  // R5 reload
        '{32'd4, 1'b1, 8'd6, 32'd2, 32'h7},  // R5 keeps running
        '{32'd1, 1'b0, 8'd1, 32'd0, 32'h7},  // R4 load of one
        '{32'd0, 1'b0, 8'd0, 32'd0, 32'h1},  // R8 no tick, no expiry
        '{32'd0, 1'b0, 8'd1, 32'd0, 32'h7}   // R8 load of zero expires
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic arm(input logic [31:0] lo, input logic [31:0] hi,
                       input logic [31:0] ctl, input logic [31:0] intv);
        wr(5'h10, 32'h0);
        wr(5'h14, intv);
        wr(5'h00, lo);
        wr(5'h04, hi);
        wr(5'h10, ctl);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // table walk
        foreach (VECS[i]) begin
            arm(VECS[i].load, 32'h0, {30'b0, 1'b1, VECS[i].per}, 32'h9);
            ticks(int'(VECS[i].ticks));
            rd(5'h08, v);
            check("R3/R4/R5 count", v, VECS[i].exp_cnt);
            rd(5'h14, v);
            check("R8/R9 int reg", v, VECS[i].exp_int);
            check("R9 irq pin", {31'b0, irq}, {31'b0, VECS[i].exp_int[2]});
        end

        // R2 + R6: 64-bit load and borrow
        arm(32'h2, 32'h1, 32'h0001_0002, 32'h9);
        rd(5'h0C, v); check("R2 wide load high", v, 32'h1);
        rd(5'h08, v); check("R2 wide load low", v, 32'h2);
        ticks(3);
        rd(5'h08, v); check("R6 borrow low", v, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R6 borrow high", v, 32'h0);

        // R2: 32-bit mode ignores load high
        arm(32'h7, 32'h5, 32'h2, 32'h9);
        rd(5'h0C, v); check("R2 narrow high zero", v, 32'h0);
        rd(5'h08, v); check("R2 narrow low", v, 32'h7);

        // R7 control fields and stop
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, v); check("R7 ctl readback", v, 32'h0001_0003);
        arm(32'h9, 32'h0, 32'h3, 32'h9);
        ticks(2);
        rd(5'h08, v); check("R7 count before stop", v, 32'h7);
        wr(5'h10, 32'h1);
        ticks(3);
        rd(5'h08, v); check("R7 stopped count held", v, 32'h7);
        rd(5'h10, v); check("R7 other fields kept", v, 32'h1);

        // R8 raw with enable off, R9 masking
        arm(32'h1, 32'h0, 32'h2, 32'h8);
        ticks(1);
        rd(5'h14, v); check("R8 raw with ie off", v, 32'h2);
        check("R9 irq masked off", {31'b0, irq}, 32'h0);
        wr(5'h14, 32'h1);
        rd(5'h14, v); check("R9 masked after ie", v, 32'h7);
        check("R9 irq asserted", {31'b0, irq}, 32'h1);

        // R10 clear and ignored status writes
        wr(5'h14, 32'h9);
        rd(5'h14, v); check("R10 clear, bit3 reads 0", v, 32'h1);
        wr(5'h14, 32'h7);
        rd(5'h14, v); check("R10 status write ignored", v, 32'h1);
        check("R10 irq low", {31'b0, irq}, 32'h0);

        // R11 expiry beats clear
        arm(32'h1, 32'h0, 32'h3, 32'h9);
        ticks(1);
        bus_addr = 5'h14; bus_wdata = 32'h9; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        rd(5'h14, v); check("R11 expiry wins over clear", v, 32'h7);

        // R12 shadow freeze across a borrow
        arm(32'h1, 32'h1, 32'h0001_0002, 32'h9);
        @(negedge clk);
        rd(5'h18, v); check("R12 shadow low", v, 32'h1);
        ticks(2);
        rd(5'h1C, v); check("R12 shadow high frozen", v, 32'h1);
        @(negedge clk);
        rd(5'h18, v); check("R12 shadow low updated", v, 32'hFFFF_FFFF);
        rd(5'h1C, v); check("R12 shadow high updated", v, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule